// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This block adds two 32-bit single-precision floating-point numbers of the same sign. Each word has a 1-bit sign, an 8-bit exponent biased by 127 and a 23-bit stored fraction with an implied leading one. The block splits each operand into sign, exponent and significand and puts the hidden one back in front. It shifts the significand of the operand with the smaller exponent right until the exponents match, adds the two significands, normalizes, rounds to nearest-even and packs the result. During the shift it does not simply drop the bits that fall off the end. It keeps the first lost bit as a guard bit and the second as a round bit, and it ORs every lower bit into a sticky bit. Those three bits decide the rounding.

The datapath has two register stages: alignment is registered first, then sum, normalize, round and pack are registered at the output. Operands enter through a valid/ready input port and results leave through a valid/ready output port. The whole pipeline advances together. When a result is waiting at the output and the downstream side is not ready, every stage holds, `in_ready` drops, and the result word stays steady until it is taken. When nothing is held, a result appears exactly two clock edges after its operands are accepted.

The supported inputs are finite, normalized operands with equal signs. Exponent overflow produces infinity. Operands with an exponent field of all zeros or all ones, and operands of opposite sign, are outside the supported range.

Top module: `fpadd_top`

## Requirements
- R1: For normalized operands of equal sign, `out_sum` is the correctly rounded sum in the format sign bit 31, exponent bits 30:23 biased by 127, fraction bits 22:0 (for example 1.0 + 2.0 = 0x40400000).
- R2: The result does not depend on operand order: the operand with the smaller exponent is the one aligned, whichever port it arrives on.
- R3: Bits shifted out during alignment are kept as guard (first bit below the 23-bit fraction), round (next bit) and sticky (OR of all lower bits), and the sum is rounded to nearest from them: 0x47A8CABF + 0x3F86B723 = 0x47A8CB46, and 0x4B800000 + 0x3F800000 = 0x4B800000.
- R4: An exact halfway case (guard 1, round 0, sticky 0) rounds to the even significand: up when the kept LSB is 1, unchanged when it is 0.
- R5: A significand sum that carries out is shifted right by one, the exponent is incremented, and the dropped bit joins the guard/round/sticky bits before rounding (0x4B800001 + 0x4B800000 = 0x4C000000).
- R6: A rounding increment that overflows the significand renormalizes to 1.0 times the next exponent (0x4B7FFFFF + 0x3F000000 = 0x4B800000).
- R7: A result exponent reaching 255 gives infinity: exponent field all ones, fraction zero, sign kept.
- R8: With `out_ready` high, `out_valid` rises exactly two rising edges after the edge that accepts `in_valid` with `in_ready` high, and no sooner.
- R9: While `out_valid` is high and `out_ready` is low, `out_sum` and `out_valid` hold, `in_ready` is low, and an `in_valid` pulse is not accepted.
- R10: After reset `out_valid` is low and `in_ready` is high.
- R11: The result sign equals the common sign of the operands (two negative operands give a negative sum).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Operand pair accepted when high with `in_valid` |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| out_valid | output | 1 | `out_sum` holds a result |
| out_ready | input | 1 | Downstream accepts the result |
| out_sum | output | 32 | Rounded sum |

## Verification
The operand pairs are picked so that each one reaches a different rounding path. The exponent gaps put the smaller operand's bits into guard only, guard plus sticky, round only, or entirely into sticky, and the results tell truncation apart from round-up and from ties-to-even with an odd or an even LSB. Equal-exponent pairs force a carry-out, which tests that the dropped bit is folded into rounding. Pairs at 0x4B7FFFFF and at the top of the exponent range drive a rounding carry into renormalization and into infinity. Swapped operand orders and negative pairs separate the alignment choice and sign handling from the arithmetic, and a stalled output run shows that held results and ignored inputs behave correctly.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  localparam int EXP_W_DEF  = 8;
  localparam int FRAC_W_DEF = 23;

  typedef struct packed {
    logic g;
    logic r;
    logic s;
  } grs_t;
endpackage

// File: rtl/fpadd_align.sv
module fpadd_align
  import fpadd_pkg::*;
#(
  parameter int EXP_W  = EXP_W_DEF,
  parameter int FRAC_W = FRAC_W_DEF,
  localparam int W      = 1 + EXP_W + FRAC_W,
  localparam int MANT_W = FRAC_W + 1
) (
  input  logic [W-1:0]      op_a,
  input  logic [W-1:0]      op_b,
  output logic              sgn,
  output logic [EXP_W-1:0]  exp_big,
  output logic [MANT_W-1:0] mant_big,
  output logic [MANT_W-1:0] mant_small,
  output grs_t              grs
);
  localparam int WIDE_W = 2 * MANT_W + 2;

  logic [EXP_W-1:0]  ea, eb, diff, exp_sm;
  logic [MANT_W-1:0] ma, mb, m_sm;
  logic              a_big;
  logic [WIDE_W-1:0] wide;

  always_comb begin
    ea    = op_a[W-2 -: EXP_W];
    eb    = op_b[W-2 -: EXP_W];
    ma    = {1'b1, op_a[FRAC_W-1:0]};
    mb    = {1'b1, op_b[FRAC_W-1:0]};
    a_big = (ea >= eb);

    sgn      = op_a[W-1];
    exp_big  = a_big ? ea : eb;
    exp_sm   = a_big ? eb : ea;
    mant_big = a_big ? ma : mb;
    m_sm     = a_big ? mb : ma;
    diff     = exp_big - exp_sm;

    wide = {m_sm, {(MANT_W+2){1'b0}}} >> diff;
    if (int'(diff) >= WIDE_W) begin
      mant_small = '0;
      grs        = '{g: 1'b0, r: 1'b0, s: 1'b1};
    end else begin
      mant_small = wide[WIDE_W-1 -: MANT_W];
      grs.g      = wide[MANT_W+1];
      grs.r      = wide[MANT_W];
      grs.s      = |wide[MANT_W-1:0];
    end
  end
endmodule

// File: rtl/fpadd_norm.sv
module fpadd_norm
  import fpadd_pkg::*;
#(
  parameter int EXP_W  = EXP_W_DEF,
  parameter int FRAC_W = FRAC_W_DEF,
  localparam int MANT_W = FRAC_W + 1
) (
  input  logic [EXP_W-1:0]  exp_in,
  input  logic [MANT_W-1:0] mant_big,
  input  logic [MANT_W-1:0] mant_small,
  input  grs_t              grs_in,
  output logic [EXP_W:0]    exp_out,
  output logic [MANT_W-1:0] mant_out,
  output grs_t              grs_out
);
  logic [MANT_W:0] sum;

  always_comb begin
    sum = {1'b0, mant_big} + {1'b0, mant_small};
    if (sum[MANT_W]) begin
      mant_out  = sum[MANT_W:1];
      grs_out.g = sum[0];
      grs_out.r = grs_in.g;
      grs_out.s = grs_in.r | grs_in.s;
      exp_out   = {1'b0, exp_in} + (EXP_W+1)'(1);
    end else begin
      mant_out = sum[MANT_W-1:0];
      grs_out  = grs_in;
      exp_out  = {1'b0, exp_in};
    end
  end
endmodule

// File: rtl/fpadd_round.sv
module fpadd_round
  import fpadd_pkg::*;
#(
  parameter int EXP_W  = EXP_W_DEF,
  parameter int FRAC_W = FRAC_W_DEF,
  localparam int W      = 1 + EXP_W + FRAC_W,
  localparam int MANT_W = FRAC_W + 1
) (
  input  logic              sgn,
  input  logic [EXP_W:0]    exp_in,
  input  logic [MANT_W-1:0] mant_in,
  input  grs_t              grs_in,
  output logic [W-1:0]      word
);
  localparam logic [EXP_W:0] EXP_TOP = {1'b0, {EXP_W{1'b1}}};

  logic            up;
  logic [MANT_W:0] rnd;
  logic [MANT_W-1:0] m2;
  logic [EXP_W:0]  e2;

  always_comb begin
    up  = grs_in.g & (grs_in.r | grs_in.s | mant_in[0]);
    rnd = {1'b0, mant_in} + {{MANT_W{1'b0}}, up};
    if (rnd[MANT_W]) begin
      m2 = rnd[MANT_W:1];
      e2 = exp_in + (EXP_W+1)'(1);
    end else begin
      m2 = rnd[MANT_W-1:0];
      e2 = exp_in;
    end
    if (e2 >= EXP_TOP)
      word = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else
      word = {sgn, e2[EXP_W-1:0], m2[FRAC_W-1:0]};
  end
endmodule

// File: rtl/fpadd_top.sv
module fpadd_top
  import fpadd_pkg::*;
#(
  parameter int EXP_W  = EXP_W_DEF,
  parameter int FRAC_W = FRAC_W_DEF,
  localparam int W      = 1 + EXP_W + FRAC_W,
  localparam int MANT_W = FRAC_W + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_sum
);
  logic              adv;
  logic              al_sgn;
  logic [EXP_W-1:0]  al_exp;
  logic [MANT_W-1:0] al_big, al_small;
  grs_t              al_grs;

  logic              s1_vld, s1_sgn;
  logic [EXP_W-1:0]  s1_exp;
  logic [MANT_W-1:0] s1_big, s1_small;
  grs_t              s1_grs;

  logic [EXP_W:0]    nm_exp;
  logic [MANT_W-1:0] nm_mant;
  grs_t              nm_grs;
  logic [W-1:0]      rd_word;

  assign adv      = !(out_valid && !out_ready);
  assign in_ready = adv;

  fpadd_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
    .op_a(in_a), .op_b(in_b), .sgn(al_sgn), .exp_big(al_exp),
    .mant_big(al_big), .mant_small(al_small), .grs(al_grs)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld   <= 1'b0;
      s1_sgn   <= 1'b0;
      s1_exp   <= '0;
      s1_big   <= '0;
      s1_small <= '0;
      s1_grs   <= '0;
    end else if (adv) begin
      s1_vld   <= in_valid;
      s1_sgn   <= al_sgn;
      s1_exp   <= al_exp;
      s1_big   <= al_big;
      s1_small <= al_small;
      s1_grs   <= al_grs;
    end
  end

  fpadd_norm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_norm (
    .exp_in(s1_exp), .mant_big(s1_big), .mant_small(s1_small), .grs_in(s1_grs),
    .exp_out(nm_exp), .mant_out(nm_mant), .grs_out(nm_grs)
  );

  fpadd_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
    .sgn(s1_sgn), .exp_in(nm_exp), .mant_in(nm_mant), .grs_in(nm_grs),
    .word(rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sum   <= '0;
    end else if (adv) begin
      out_valid <= s1_vld;
      out_sum   <= rd_word;
    end
  end
endmodule

// File: rtl/fpadd_chk.sv
module fpadd_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W = 1 + EXP_W + FRAC_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_sum
);
  a_r9_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum)));

  a_r9_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r7_inf_zero_frac: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (&out_sum[W-2 -: EXP_W])) |-> (out_sum[FRAC_W-1:0] == '0));

  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready, 2));

  a_r1_exp_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sum[W-2 -: EXP_W] != '0));
endmodule

bind fpadd_top fpadd_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_sum(out_sum)
);

// File: tb/sim_fpadd_top.sv
module sim_fpadd_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;

  // {a, b, expected}
  localparam logic [95:0] VEC [NVEC] = '{
    {32'h47A8CABF, 32'h3F86B723, 32'h47A8CB46}, // R3 guard+sticky round up
    {32'h4B800000, 32'h3F800000, 32'h4B800000}, // R3 R4 tie, even kept
    {32'h3F800000, 32'h40000000, 32'h40400000}, // R1 1+2=3
    {32'h3F800000, 32'h3F800000, 32'h40000000}, // R5 carry-out exact
    {32'h3FC00000, 32'h3FC00000, 32'h40400000}, // R1 1.5+1.5
    {32'h4B800001, 32'h3F800000, 32'h4B800002}, // R4 tie, odd rounds up
    {32'h4B800000, 32'h3F800001, 32'h4B800001}, // R3 guard+sticky
    {32'h4B800000, 32'h3F000000, 32'h4B800000}, // R3 round bit only
    {32'h4B800001, 32'h4B800000, 32'h4C000000}, // R5 dropped bit tie even
    {32'h4B800003, 32'h4B800000, 32'h4C000002}, // R5 dropped bit tie odd
    {32'h4B7FFFFF, 32'h3F000000, 32'h4B800000}, // R6 rounding carry
    {32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7F800000}, // R7 overflow by carry
    {32'h7F7FFFFF, 32'h73000000, 32'h7F800000}, // R7 overflow by rounding
    {32'h3F86B723, 32'h47A8CABF, 32'h47A8CB46}, // R2 swapped order
    {32'h3F800000, 32'h7F000000, 32'h7F000000}, // R2 sticky only, swapped
    {32'hBF800000, 32'hBF800000, 32'hC0000000}  // R11 negative pair
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_sum;

  int n_checks = 0;
  int n_fail   = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpadd_top u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_sum(out_sum)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 out_valid", {31'b0, out_valid}, 32'd0);
    check("R10 in_ready", {31'b0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      in_a = VEC[i][95:64];
      in_b = VEC[i][63:32];
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R8 not early", {31'b0, out_valid}, 32'd0);
      @(negedge clk);
      check("R8 valid at 2", {31'b0, out_valid}, 32'd1);
      check($sformatf("R1 vector %0d", i), out_sum, VEC[i][31:0]);
      @(negedge clk);
    end

    // R9 back-pressure: result held, input ignored
    out_ready = 1'b0;
    in_a = 32'h3F800000; in_b = 32'h40000000; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check("R9 valid", {31'b0, out_valid}, 32'd1);
    check("R9 in_ready low", {31'b0, in_ready}, 32'd0);
    in_a = 32'h3F800000; in_b = 32'h3F800000; in_valid = 1'b1;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    check("R9 held valid", {31'b0, out_valid}, 32'd1);
    check("R9 held data", out_sum, 32'h40400000);
    out_ready = 1'b1;
    @(negedge clk);
    check("R9 ignored input", {31'b0, out_valid}, 32'd0);
    @(negedge clk);
    check("R9 ignored input later", {31'b0, out_valid}, 32'd0);

    // Back-to-back stream, R8
    in_a = 32'h3F800000; in_b = 32'h3F800000; in_valid = 1'b1;
    @(negedge clk);
    in_a = 32'hBF800000; in_b = 32'hC0000000;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 stream first", out_sum, 32'h40000000);
    @(negedge clk);
    check("R11 stream second", out_sum, 32'hC0400000);
    check("R8 stream valid", {31'b0, out_valid}, 32'd1);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule